// File: doc/BRIEF.md
# Bilinear Standard-Definition Frame Scaler

This block takes a gray 8-bit picture of programmable size and resamples it to a fixed 720×576 output raster by bilinear blending. It needs no frame store. Two row memories hold the pair of source rows that bracket the current output row. A coordinate stepper walks through the source plane in 8.8 fixed point, one output pixel per clock. A two-stage blend pipeline mixes the four neighbouring source pixels with the fractional weights.

The block paces its source. While it is loading a row it raises `in_ready`, and it accepts one pixel on each clock that has `in_valid` high. While it is producing an output row it holds `in_ready` low. The horizontal and vertical steps are supplied as configuration inputs. Each step equals the input size divided by the output size, so 640×512 to 720×576 uses 228 horizontally and 228 vertically. The width, height and steps are captured when a frame starts. Width and height must be at least 1.

Top module: `sd_bilinear_scaler`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: When the block is idle, it starts a frame only on a pixel that has both `in_valid` and `in_sof` high. That pixel is stored as column 0 of row 0. Other pixels accepted while idle are dropped and do not affect any output.
- R3: Each frame produces OUT_W×OUT_H pixels in raster order (720×576 by default). `out_sof` is high only with the first pixel of the frame. `out_sol` is high with the first pixel of every output row.
- R4: Output pixel (i, j) maps to source coordinates x = i·step_x and y = j·step_y, each with 8 fractional bits. The integer parts select column and row. The low 8 bits are dx and dy. A step of 256 reproduces the source pixels exactly.
- R5: The output value is ((256−dx)(256−dy)P1 + dx(256−dy)P2 + (256−dx)dy·P3 + dx·dy·P4 + 32768) >> 16. P1 is at (x,y), P2 at (x+1,y), P3 at (x,y+1) and P4 at (x+1,y+1).
- R6: A column index beyond width−1 is replaced by width−1. A row index beyond height−1 is replaced by height−1. As a result, the last column and the last row are replicated.
- R7: `in_ready` is low on every clock that issues an output pixel. Source rows are taken strictly in order. A pixel with `in_sol` high during a row load restarts that row at column 0. Source rows left over after the last output row are accepted while idle and discarded.
- R8: Each output pixel appears two clock edges after its coordinate is issued. The pixels of one output row leave on consecutive clocks, and every run of `out_valid` begins with `out_sol`.
- R9: Changes to width, height or either step after the start-of-frame pixel have no effect on the frame in progress.
- R10: The horizontal and vertical steps act independently. Each step may be below 256 (enlarging) or above 256 (shrinking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in_width | input | $clog2(MAX_W+1) | Source width in pixels, captured at frame start |
| cfg_in_height | input | $clog2(MAX_H+1) | Source height in rows, captured at frame start |
| cfg_step_x | input | STEP_W | Horizontal source step per output pixel, 8.8 fixed point |
| cfg_step_y | input | STEP_W | Vertical source step per output row, 8.8 fixed point |
| in_valid | input | 1 | Source pixel present |
| in_sof | input | 1 | Source pixel is the first of a frame |
| in_sol | input | 1 | Source pixel is the first of a row |
| in_pix | input | 8 | Source gray value |
| in_ready | output | 1 | Block accepts a source pixel this clock |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First output pixel of the frame |
| out_sol | output | 1 | First output pixel of a row |
| out_pix | output | 8 | Interpolated gray value |

## Verification
An output pixel is due two edges after the clock that issues its coordinate, and the whole output row follows on back-to-back clocks. The bench does not rely on the idle gaps between rows, which depend on how many source rows still have to load. It samples on the falling edge and pops a reference queue for every clock with `out_valid` high, so values, markers and order are all checked. Row contiguity is checked separately: a counter expects `out_valid` on each of the OUT_W−1 clocks that follow an `out_sol`. The fixed two-edge latency is checked with a property against the internal issue strobe.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;
  localparam int ONE    = 1 << FRAC_W;
  localparam int WGT_W  = FRAC_W + 1;
  localparam int SUM_W  = PIX_W + 2 * WGT_W + 2;
  localparam int HALF   = (ONE * ONE) / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PLAN,
    ST_EMIT
  } step_state_e;

  // four-tap weighted blend, rounded, weights sum to ONE*ONE
  function automatic logic [PIX_W-1:0] bilerp(
    input logic [PIX_W-1:0]  p_ul,
    input logic [PIX_W-1:0]  p_ur,
    input logic [PIX_W-1:0]  p_ll,
    input logic [PIX_W-1:0]  p_lr,
    input logic [FRAC_W-1:0] fx,
    input logic [FRAC_W-1:0] fy
  );
    logic [SUM_W-1:0] wx1, wx0, wy1, wy0, acc;
    wx1 = SUM_W'(fx);
    wy1 = SUM_W'(fy);
    wx0 = SUM_W'(ONE) - wx1;
    wy0 = SUM_W'(ONE) - wy1;
    acc = wx0 * wy0 * SUM_W'(p_ul)
        + wx1 * wy0 * SUM_W'(p_ur)
        + wx0 * wy1 * SUM_W'(p_ll)
        + wx1 * wy1 * SUM_W'(p_lr)
        + SUM_W'(HALF);
    return acc[2*FRAC_W +: PIX_W];
  endfunction
endpackage

// File: rtl/sbs_row_store.sv
module sbs_row_store
  import sbs_pkg::*;
#(
  parameter int MAX_W = 1024,
  localparam int AW = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             rd_up_sel,
  input  logic             rd_lo_sel,
  input  logic [AW-1:0]    rd_a0,
  input  logic [AW-1:0]    rd_a1,
  output logic [PIX_W-1:0] p_ul,
  output logic [PIX_W-1:0] p_ur,
  output logic [PIX_W-1:0] p_ll,
  output logic [PIX_W-1:0] p_lr
);
  logic [PIX_W-1:0] rd0 [2];
  logic [PIX_W-1:0] rd1 [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] mem [MAX_W];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign rd0[b] = mem[rd_a0];
    assign rd1[b] = mem[rd_a1];
  end

  // registered neighbour fetch, one cycle after address issue
  always_ff @(posedge clk) begin
    p_ul <= rd0[rd_up_sel];
    p_ur <= rd1[rd_up_sel];
    p_ll <= rd0[rd_lo_sel];
    p_lr <= rd1[rd_lo_sel];
  end
endmodule

// File: rtl/sbs_coord_step.sv
module sbs_coord_step
  import sbs_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 1024,
  parameter int OUT_W  = 720,
  parameter int OUT_H  = 576,
  parameter int STEP_W = 16,
  localparam int AW    = $clog2(MAX_W),
  localparam int WD_W  = $clog2(MAX_W + 1),
  localparam int HD_W  = $clog2(MAX_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WD_W-1:0]   cfg_in_width,
  input  logic [HD_W-1:0]   cfg_in_height,
  input  logic [STEP_W-1:0] cfg_step_x,
  input  logic [STEP_W-1:0] cfg_step_y,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_sol,
  output logic              in_ready,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [AW-1:0]     wr_addr,
  output logic              rd_up_sel,
  output logic              rd_lo_sel,
  output logic [AW-1:0]     rd_a0,
  output logic [AW-1:0]     rd_a1,
  output logic              iss_valid,
  output logic              iss_sof,
  output logic              iss_sol,
  output logic [FRAC_W-1:0] iss_dx,
  output logic [FRAC_W-1:0] iss_dy
);
  localparam int OXW   = $clog2(OUT_W);
  localparam int OYW   = $clog2(OUT_H);
  localparam int SPAN  = (OUT_W > OUT_H) ? OUT_W : OUT_H;
  localparam int ACC_W = STEP_W + $clog2(SPAN) + 1;
  localparam int IW    = ACC_W - FRAC_W + 1;

  step_state_e      state;
  logic             up_sel, wsel;
  logic [AW-1:0]    col;
  logic [HD_W-1:0]  rows_in, top;
  logic [ACC_W-1:0] x_acc, y_acc;
  logic [OXW-1:0]   ox;
  logic [OYW-1:0]   oy;
  logic [WD_W-1:0]  w_r;
  logic [HD_W-1:0]  h_r;
  logic [STEP_W-1:0] sx_r, sy_r;

  function automatic logic [AW-1:0] clamp_col(input logic [IW-1:0] idx,
                                              input logic [WD_W-1:0] lim);
    return (idx > IW'(lim)) ? lim[AW-1:0] : idx[AW-1:0];
  endfunction

  function automatic logic [HD_W-1:0] clamp_row(input logic [IW-1:0] idx,
                                               input logic [HD_W-1:0] lim);
    return (idx > IW'(lim)) ? lim : idx[HD_W-1:0];
  endfunction

  logic [WD_W-1:0] lim_w;
  logic [HD_W-1:0] lim_h, yi_c;
  logic [IW-1:0]   xi, xi1, yi;
  logic            lower_rep, need_load, need_promote;
  logic [AW-1:0]   ec;
  logic            load_last, start_ev, row_end, frame_end;

  assign lim_w = w_r - WD_W'(1);
  assign lim_h = h_r - HD_W'(1);
  assign xi    = IW'(x_acc[ACC_W-1:FRAC_W]);
  assign xi1   = xi + IW'(1);
  assign yi    = IW'(y_acc[ACC_W-1:FRAC_W]);
  assign yi_c  = clamp_row(yi, lim_h);

  // lower row is a copy of the upper one at the bottom edge
  assign lower_rep    = (top == lim_h);
  assign need_load    = (rows_in == top + HD_W'(1)) && (rows_in < h_r);
  assign need_promote = (yi_c > top);

  assign ec        = in_sol ? '0 : col;
  assign load_last = (WD_W'(ec) == lim_w);
  assign start_ev  = (state == ST_IDLE) && in_valid && in_sof;
  assign row_end   = (ox == OXW'(OUT_W - 1));
  assign frame_end = (oy == OYW'(OUT_H - 1));

  assign in_ready  = (state == ST_IDLE) || (state == ST_LOAD);
  assign wr_en     = start_ev || ((state == ST_LOAD) && in_valid);
  assign wr_sel    = (state == ST_IDLE) ? up_sel : wsel;
  assign wr_addr   = (state == ST_IDLE) ? '0 : ec;

  assign rd_up_sel = up_sel;
  assign rd_lo_sel = lower_rep ? up_sel : ~up_sel;
  assign rd_a0     = clamp_col(xi, lim_w);
  assign rd_a1     = clamp_col(xi1, lim_w);
  assign iss_valid = (state == ST_EMIT);
  assign iss_sol   = (ox == '0);
  assign iss_sof   = (ox == '0) && (oy == '0);
  assign iss_dx    = x_acc[FRAC_W-1:0];
  assign iss_dy    = y_acc[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      up_sel  <= 1'b0;
      wsel    <= 1'b0;
      col     <= '0;
      rows_in <= '0;
      top     <= '0;
      x_acc   <= '0;
      y_acc   <= '0;
      ox      <= '0;
      oy      <= '0;
      w_r     <= WD_W'(1);
      h_r     <= HD_W'(1);
      sx_r    <= '0;
      sy_r    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ev) begin
            w_r   <= cfg_in_width;
            h_r   <= cfg_in_height;
            sx_r  <= cfg_step_x;
            sy_r  <= cfg_step_y;
            top   <= '0;
            y_acc <= '0;
            oy    <= '0;
            wsel  <= up_sel;
            if (cfg_in_width == WD_W'(1)) begin
              rows_in <= HD_W'(1);
              state   <= ST_PLAN;
            end else begin
              rows_in <= '0;
              col     <= AW'(1);
              state   <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            if (load_last) begin
              rows_in <= rows_in + HD_W'(1);
              state   <= ST_PLAN;
            end else begin
              col <= ec + AW'(1);
            end
          end
        end
        ST_PLAN: begin
          if (need_load) begin
            wsel  <= ~up_sel;
            col   <= '0;
            state <= ST_LOAD;
          end else if (need_promote) begin
            up_sel <= ~up_sel;
            top    <= top + HD_W'(1);
          end else begin
            x_acc <= '0;
            ox    <= '0;
            state <= ST_EMIT;
          end
        end
        default: begin
          x_acc <= x_acc + ACC_W'(sx_r);
          ox    <= ox + OXW'(1);
          if (row_end) begin
            y_acc <= y_acc + ACC_W'(sy_r);
            oy    <= oy + OYW'(1);
            state <= frame_end ? ST_IDLE : ST_PLAN;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sbs_blend.sv
module sbs_blend
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_sof,
  input  logic              iss_sol,
  input  logic [FRAC_W-1:0] iss_dx,
  input  logic [FRAC_W-1:0] iss_dy,
  input  logic [PIX_W-1:0]  p_ul,
  input  logic [PIX_W-1:0]  p_ur,
  input  logic [PIX_W-1:0]  p_ll,
  input  logic [PIX_W-1:0]  p_lr,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic [PIX_W-1:0]  out_pix
);
  logic              v1, sof1, sol1;
  logic [FRAC_W-1:0] dx1, dy1;

  // stage 1 aligns weights with the registered neighbour fetch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      sof1 <= 1'b0;
      sol1 <= 1'b0;
      dx1  <= '0;
      dy1  <= '0;
    end else begin
      v1   <= iss_valid;
      sof1 <= iss_valid && iss_sof;
      sol1 <= iss_valid && iss_sol;
      dx1  <= iss_dx;
      dy1  <= iss_dy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      out_sof   <= sof1;
      out_sol   <= sol1;
      out_pix   <= v1 ? bilerp(p_ul, p_ur, p_ll, p_lr, dx1, dy1) : '0;
    end
  end
endmodule

// File: rtl/sd_bilinear_scaler.sv
module sd_bilinear_scaler
  import sbs_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 1024,
  parameter int OUT_W  = 720,
  parameter int OUT_H  = 576,
  parameter int STEP_W = 16,
  localparam int WD_W  = $clog2(MAX_W + 1),
  localparam int HD_W  = $clog2(MAX_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WD_W-1:0]   cfg_in_width,
  input  logic [HD_W-1:0]   cfg_in_height,
  input  logic [STEP_W-1:0] cfg_step_x,
  input  logic [STEP_W-1:0] cfg_step_y,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic [7:0]        in_pix,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_sol,
  output logic [7:0]        out_pix
);
  localparam int AW = $clog2(MAX_W);

  logic              buf_wr_en, buf_wr_sel;
  logic [AW-1:0]     buf_wr_addr, rd_a0, rd_a1;
  logic              rd_up_sel, rd_lo_sel;
  logic              issue_fire, iss_sof, iss_sol;
  logic [FRAC_W-1:0] iss_dx, iss_dy;
  logic [PIX_W-1:0]  p_ul, p_ur, p_ll, p_lr;

  sbs_coord_step #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .OUT_W(OUT_W), .OUT_H(OUT_H), .STEP_W(STEP_W)
  ) u_step (
    .clk(clk), .rst_n(rst_n),
    .cfg_in_width(cfg_in_width), .cfg_in_height(cfg_in_height),
    .cfg_step_x(cfg_step_x), .cfg_step_y(cfg_step_y),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_ready(in_ready),
    .wr_en(buf_wr_en), .wr_sel(buf_wr_sel), .wr_addr(buf_wr_addr),
    .rd_up_sel(rd_up_sel), .rd_lo_sel(rd_lo_sel), .rd_a0(rd_a0), .rd_a1(rd_a1),
    .iss_valid(issue_fire), .iss_sof(iss_sof), .iss_sol(iss_sol),
    .iss_dx(iss_dx), .iss_dy(iss_dy)
  );

  sbs_row_store #(.MAX_W(MAX_W)) u_rows (
    .clk(clk),
    .wr_en(buf_wr_en), .wr_sel(buf_wr_sel), .wr_addr(buf_wr_addr), .wr_data(in_pix),
    .rd_up_sel(rd_up_sel), .rd_lo_sel(rd_lo_sel), .rd_a0(rd_a0), .rd_a1(rd_a1),
    .p_ul(p_ul), .p_ur(p_ur), .p_ll(p_ll), .p_lr(p_lr)
  );

  sbs_blend u_blend (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(issue_fire), .iss_sof(iss_sof), .iss_sol(iss_sol),
    .iss_dx(iss_dx), .iss_dy(iss_dy),
    .p_ul(p_ul), .p_ur(p_ur), .p_ll(p_ll), .p_lr(p_lr),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_pix(out_pix)
  );
endmodule

// File: rtl/sd_bilinear_scaler_chk.sv
module sd_bilinear_scaler_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_sof,
  input logic out_sol,
  input logic issue_fire,
  input logic wr_en
);
  // R7
  ready_low_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !in_ready);

  // R7
  no_write_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !issue_fire);

  // R8
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> ##2 out_valid);

  // R8
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> out_sol);

  // R3
  sof_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && out_sol));
endmodule

bind sd_bilinear_scaler sd_bilinear_scaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
  .issue_fire(issue_fire), .wr_en(buf_wr_en)
);

// File: tb/tb_sd_bilinear_scaler.sv
module tb_sd_bilinear_scaler;
  localparam int TB_MAX_W = 64;
  localparam int TB_MAX_H = 64;
  localparam int OW = 24;
  localparam int OH = 12;
  localparam int TB_WD_W = $clog2(TB_MAX_W + 1);
  localparam int TB_HD_W = $clog2(TB_MAX_H + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TB_WD_W-1:0] cfg_in_width = '0;
  logic [TB_HD_W-1:0] cfg_in_height = '0;
  logic [15:0] cfg_step_x = '0, cfg_step_y = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [7:0] in_pix = '0;
  logic in_ready, out_valid, out_sof, out_sol;
  logic [7:0] out_pix;

  always #5 clk = ~clk;

  sd_bilinear_scaler #(
    .MAX_W(TB_MAX_W), .MAX_H(TB_MAX_H), .OUT_W(OW), .OUT_H(OH), .STEP_W(16)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_in_width(cfg_in_width), .cfg_in_height(cfg_in_height),
    .cfg_step_x(cfg_step_x), .cfg_step_y(cfg_step_y),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
    .out_sol(out_sol), .out_pix(out_pix)
  );

  int checks = 0, errors = 0;
  int img [0:63][0:63];
  int exp_q [$];
  string cur_tag = "R1";
  bit mon_on = 1'b0;
  int run = 0;
  int rx = 0;
  bit done = 1'b0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic int clampi(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic int ref_px(int ox, int oy, int w, int h, int sx, int sy);
    int xa = ox * sx, ya = oy * sy;
    int dx = xa % 256, dy = ya % 256;
    int x0 = clampi(xa / 256, w - 1), x1 = clampi(xa / 256 + 1, w - 1);
    int y0 = clampi(ya / 256, h - 1), y1 = clampi(ya / 256 + 1, h - 1);
    int s = (256 - dx) * (256 - dy) * img[y0][x0] + dx * (256 - dy) * img[y0][x1]
          + (256 - dx) * dy * img[y1][x0] + dx * dy * img[y1][x1] + 32768;
    return s / 65536;
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (run > 0 && run < OW) begin
        checks++;
        if (!out_valid || out_sol) begin
          errors++;
          $display("FAIL R8 row run broken at %0d: valid=%0b sol=%0b exp valid=1 sol=0",
                   run, out_valid, out_sol);
        end
        run++;
      end
      if (out_valid && out_sol) run = 1;
      if (out_valid) begin
        int got;
        got = {out_sof, out_sol, out_pix};
        checks++;
        rx++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 extra output pixel: act=%0h exp=none", got);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (got != e) begin
            errors++;
            $display("FAIL %s pixel: act sof=%0b sol=%0b pix=%0d exp sof=%0b sol=%0b pix=%0d",
                     cur_tag, got[9], got[8], got[7:0], e[9], e[8], e[7:0]);
          end
        end
      end
    end
  end

  task automatic drive_px(bit sof, bit sol, int pix);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_sof = sof;
    in_sol = sol;
    in_pix = 8'(pix);
  endtask

  task automatic send_frame(int fi, int w, int h, int sx, int sy,
                            bit junk, bit mess, string tag);
    cur_tag = tag;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        img[r][c] = (r * 37 + c * 11 + fi * 53 + ((r * c) % 7) * 19) % 256;
    for (int j = 0; j < OH; j++)
      for (int i = 0; i < OW; i++)
        exp_q.push_back(((i == 0 && j == 0) ? 512 : 0) + ((i == 0) ? 256 : 0)
                        + ref_px(i, j, w, h, sx, sy));
    rx = 0;
    cfg_in_width = TB_WD_W'(w);
    cfg_in_height = TB_HD_W'(h);
    cfg_step_x = 16'(sx);
    cfg_step_y = 16'(sy);
    if (junk) begin
      // R2: pixels without a frame marker while idle are dropped
      for (int k = 0; k < 3; k++) drive_px(1'b0, k == 0, 200 + k);
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (!in_ready || out_valid) begin
        errors++;
        $display("FAIL R2 idle after stray pixels: ready=%0b valid=%0b exp ready=1 valid=0",
                 in_ready, out_valid);
      end
    end
    for (int r = 0; r < h; r++) begin
      if (mess && r == 1)
        for (int k = 0; k < 3; k++) drive_px(1'b0, k == 0, 90 + k);  // R7 restart
      if (mess && r == h / 2) begin
        // R9: new settings mid-frame must not matter
        cfg_in_width = TB_WD_W'(3);
        cfg_in_height = TB_HD_W'(2);
        cfg_step_x = 16'd999;
        cfg_step_y = 16'd5;
      end
      for (int c = 0; c < w; c++) drive_px(r == 0 && c == 0, c == 0, img[r][c]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_sol = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (rx != OW * OH) begin
      errors++;
      $display("FAIL R3 frame pixel count: act=%0d exp=%0d", rx, OW * OH);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_valid after reset: act=%0b exp=0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in_ready after reset: act=%0b exp=1", in_ready);
    end
    mon_on = 1'b1;
    send_frame(1, 16, 8, 171, 171, 1'b0, 1'b0, "R5/R10");
    send_frame(2, 40, 30, 427, 640, 1'b1, 1'b1, "R9/R2/R7");
    send_frame(3, 5, 3, 300, 200, 1'b0, 1'b0, "R6");
    send_frame(4, 1, 1, 100, 100, 1'b0, 1'b0, "R6");
    send_frame(5, 30, 12, 256, 256, 1'b0, 1'b0, "R4");
    send_frame(6, 10, 20, 100, 430, 1'b1, 1'b0, "R10");
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: act=hung exp=finished");
      report();
      $finish;
    end
  end
endmodule